// File: doc/BRIEF.md
# Auxiliary-Channel Request Engine

This block is the register front end of a display auxiliary-channel transaction engine. Software sees byte-wide registers on a simple address/data bus. Through them it loads a 20-bit target address, a 4-bit request code and a payload length, and pushes up to 16 outgoing bytes. It then sets a start bit. The engine presents one request to a downstream link port, which stands in for the serial PHY. That port fetches the outgoing bytes, delivers any returned bytes into a receive queue, and ends the request with a reply class and a byte count. The engine then packs the class and the count into a status byte and clears the start bit.

A sequencer with three named states drives the exchange. IDLE waits for a start. It moves to OFFER on a start write (transition *launch*). OFFER holds the request valid until the link accepts it and then moves to AWAIT (transition *accepted*). AWAIT returns to IDLE when the link reports completion (transition *finish*). OFFER and AWAIT both return to IDLE when a cycle budget runs out (transition *expire*). Any state returns to IDLE on a channel reset (transition *flush*).

Top module: `aux_req_engine`

## Requirements
- R1: Offsets 0x7D and 0x7E hold target address bits 7:0 and 15:8. Bits 3:0 of offset 0x7F hold address bits 19:16 and bits 7:4 hold the request code. All three read back as written and appear on `lnk_addr` and `lnk_cmd`.
- R2: Offset 0x80 holds the byte count minus one in bits 3:0. When bit 7 is set, the request carries no payload. `lnk_len` is 0 for a no-payload request and the field plus one otherwise. Readback shows bits 7 and 3:0 only.
- R3: Each write to offset 0x81 appends one byte to a 16-entry transmit queue. The link takes the bytes in write order with `lnk_tx_pop`. A write to a full queue is dropped.
- R4: Each read of offset 0x82 returns the oldest received byte and removes it. A read of an empty queue returns 0 and changes nothing.
- R5: Writing 1 to bit 0 of offset 0x83 while idle starts a request. The bit reads 1 from the next cycle until completion and then clears by itself. Start writes while busy are ignored, and `lnk_req_valid` stays high until `lnk_req_ready`.
- R6: On completion, offset 0x84 shows the link class in bits 7:5 (1 native NACK, 2 native DEFER, 3 ACK, 4 invalid, 5 I2C NACK, 6 I2C DEFER, 7 timeout). Bits 4:0 show the link count for classes 1, 2, 3, 5 and 6, and 0 otherwise.
- R7: If no completion arrives within `TMO_CYCLES` cycles of the start, the status becomes 0xE0 and the start bit clears.
- R8: Writing 0xFF to offset 0x76 empties both queues, zeroes the status and returns the sequencer to IDLE. Any other value written there has no effect.
- R9: Reads of any other offset return 0, and writes to them change nothing.
- R10: A receive push from the link and a bus read of 0x82 in the same cycle both take effect.
- R11: After reset, the status reads 0, the start bit reads 0 and `lnk_req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on 0x82) |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the offset |
| lnk_req_valid | output | 1 | Request offered to the link |
| lnk_req_ready | input | 1 | Link accepts the request |
| lnk_cmd | output | 4 | Request code |
| lnk_addr | output | 20 | Target address |
| lnk_len | output | 5 | Payload bytes, 0 to 16 |
| lnk_tx_data | output | 8 | Head of the transmit queue, 0 when empty |
| lnk_tx_pop | input | 1 | Link takes one transmit byte |
| lnk_rx_push | input | 1 | Link delivers one received byte |
| lnk_rx_data | input | 8 | Received byte |
| lnk_done | input | 1 | Link completion pulse |
| lnk_class | input | 3 | Reply class on completion |
| lnk_count | input | 5 | Byte count on completion |

## Verification
The receive queue is the point where two functions meet. The link pushes into it while the bus pops from it. The bench provokes this by keeping a request in AWAIT with one byte already queued. It then raises `lnk_rx_push` in the same cycle as a read of 0x82. That read must return the older byte, and the next read must return the newer one. A third read must see an empty queue and return 0. A scoreboard queue of delivered bytes supplies every expected value.

// File: rtl/aux_pkg.sv
package aux_pkg;
    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] OFF_CFG   = 8'h76;
    localparam logic [7:0] OFF_ADR0  = 8'h7D;
    localparam logic [7:0] OFF_ADR1  = 8'h7E;
    localparam logic [7:0] OFF_ADR2  = 8'h7F;
    localparam logic [7:0] OFF_LEN   = 8'h80;
    localparam logic [7:0] OFF_WDAT  = 8'h81;
    localparam logic [7:0] OFF_RDAT  = 8'h82;
    localparam logic [7:0] OFF_CTRL  = 8'h83;
    localparam logic [7:0] OFF_STAT  = 8'h84;

    localparam logic [7:0] CFG_FLUSH = 8'hFF;

    localparam logic [2:0] CLS_INVALID = 3'd4;
    localparam logic [2:0] CLS_TIMEOUT = 3'd7;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_OFFER = 2'd1,
        SQ_AWAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/aux_fifo.sv
module aux_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rp, wp;
    logic [CW-1:0]    cnt;
    logic             pop_ok, push_ok;

    assign pop_ok  = pop && (cnt != '0);
    assign push_ok = push && ((cnt != FULL) || pop_ok);
    assign dout    = (cnt == '0) ? '0 : mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wp] <= din;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt == '0 && !push && !flush) |=> (cnt == '0));
endmodule

// File: rtl/aux_seq.sv
module aux_seq
    import aux_pkg::*;
#(
    parameter int unsigned TMO_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       chan_rst,
    input  logic       lnk_req_ready,
    input  logic       lnk_done,
    input  logic [2:0] lnk_class,
    input  logic [4:0] lnk_count,
    output logic       busy,
    output logic       lnk_req_valid,
    output logic       stat_we,
    output logic [7:0] stat_val
);
    localparam int unsigned TW = $clog2(TMO_CYCLES + 1);
    localparam logic [TW-1:0] TLAST = TW'(TMO_CYCLES - 1);

    seq_state_t st, st_nx;
    logic [TW-1:0] tmr;
    logic expire;
    logic finish;

    assign expire = (st != SQ_IDLE) && (tmr == TLAST);
    assign finish = (st == SQ_AWAIT) && lnk_done;

    always_comb begin
        st_nx = st;
        if (chan_rst) begin
            st_nx = SQ_IDLE;
        end else begin
            unique case (st)
                SQ_IDLE:  if (go) st_nx = SQ_OFFER;
                SQ_OFFER: if (expire) st_nx = SQ_IDLE;
                          else if (lnk_req_ready) st_nx = SQ_AWAIT;
                SQ_AWAIT: if (finish || expire) st_nx = SQ_IDLE;
                default:  st_nx = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            tmr <= '0;
        end else begin
            st <= st_nx;
            if (st == SQ_IDLE) tmr <= '0;
            else if (!expire)  tmr <= tmr + 1'b1;
        end
    end

    always_comb begin
        busy          = (st != SQ_IDLE);
        lnk_req_valid = (st == SQ_OFFER);
        stat_we       = 1'b0;
        stat_val      = '0;
        if (!chan_rst) begin
            if (finish) begin
                stat_we = 1'b1;
                stat_val[7:5] = lnk_class;
                if (lnk_class != 3'd0 && lnk_class != CLS_INVALID && lnk_class != CLS_TIMEOUT)
                    stat_val[4:0] = lnk_count;
            end else if (expire) begin
                stat_we  = 1'b1;
                stat_val = {CLS_TIMEOUT, 5'd0};
            end
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_req_valid && !lnk_req_ready && !chan_rst && !expire) |=> lnk_req_valid);
    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_AWAIT && lnk_done) |=> !busy);
    p_tmr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= TLAST);
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
    import aux_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned TMO_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        lnk_req_valid,
    input  logic        lnk_req_ready,
    output logic [3:0]  lnk_cmd,
    output logic [19:0] lnk_addr,
    output logic [4:0]  lnk_len,
    output logic [7:0]  lnk_tx_data,
    input  logic        lnk_tx_pop,
    input  logic        lnk_rx_push,
    input  logic [7:0]  lnk_rx_data,
    input  logic        lnk_done,
    input  logic [2:0]  lnk_class,
    input  logic [4:0]  lnk_count
);
    logic [7:0] adr0_q, adr1_q, adr2_q, len_q, stat_q;
    logic       busy, stat_we, go, chan_rst, rx_pop;
    logic [7:0] stat_val, rx_head;

    assign chan_rst = reg_wr && (reg_addr == OFF_CFG) && (reg_wdata == CFG_FLUSH);
    assign go       = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[0] && !busy;
    assign rx_pop   = reg_rd && (reg_addr == OFF_RDAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adr0_q <= '0;
            adr1_q <= '0;
            adr2_q <= '0;
            len_q  <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                OFF_ADR0: adr0_q <= reg_wdata;
                OFF_ADR1: adr1_q <= reg_wdata;
                OFF_ADR2: adr2_q <= reg_wdata;
                OFF_LEN:  len_q  <= {reg_wdata[7], 3'b000, reg_wdata[3:0]};
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stat_q <= '0;
        else if (chan_rst) stat_q <= '0;
        else if (stat_we)  stat_q <= stat_val;
    end

    always_comb begin
        unique case (reg_addr)
            OFF_ADR0: reg_rdata = adr0_q;
            OFF_ADR1: reg_rdata = adr1_q;
            OFF_ADR2: reg_rdata = adr2_q;
            OFF_LEN:  reg_rdata = len_q;
            OFF_RDAT: reg_rdata = rx_head;
            OFF_CTRL: reg_rdata = {7'd0, busy};
            OFF_STAT: reg_rdata = stat_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign lnk_addr = {adr2_q[3:0], adr1_q, adr0_q};
    assign lnk_cmd  = adr2_q[7:4];
    assign lnk_len  = len_q[7] ? 5'd0 : ({1'b0, len_q[3:0]} + 5'd1);

    aux_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(chan_rst),
        .push(reg_wr && (reg_addr == OFF_WDAT)), .din(reg_wdata),
        .pop(lnk_tx_pop), .dout(lnk_tx_data)
    );

    aux_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(chan_rst),
        .push(lnk_rx_push), .din(lnk_rx_data),
        .pop(rx_pop), .dout(rx_head)
    );

    aux_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .chan_rst(chan_rst),
        .lnk_req_ready(lnk_req_ready), .lnk_done(lnk_done),
        .lnk_class(lnk_class), .lnk_count(lnk_count),
        .busy(busy), .lnk_req_valid(lnk_req_valid),
        .stat_we(stat_we), .stat_val(stat_val)
    );

    p_flush_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (stat_q == 8'h00 && !busy));
    p_count_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[7:5] == CLS_INVALID || stat_q[7:5] == CLS_TIMEOUT) |-> (stat_q[4:0] == 5'd0));
    p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !chan_rst) |=> lnk_req_valid);
endmodule

// File: tb/aux_req_engine_test.sv
module aux_req_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = 0, reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic lnk_req_valid, lnk_req_ready = 0;
    logic [3:0] lnk_cmd;
    logic [19:0] lnk_addr;
    logic [4:0] lnk_len;
    logic [7:0] lnk_tx_data;
    logic lnk_tx_pop = 0, lnk_rx_push = 0, lnk_done = 0;
    logic [7:0] lnk_rx_data = 0;
    logic [2:0] lnk_class = 0;
    logic [4:0] lnk_count = 0;

    int n_tests = 0, n_fail = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    aux_req_engine #(.FIFO_DEPTH(16), .TMO_CYCLES(20)) uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        peek(a, d);
        check(tag, {24'd0, d}, {24'd0, exp});
    endtask

    // driver side: push a byte to transmit queue and scoreboard
    task automatic drv_tx(input logic [7:0] d);
        wr(8'h81, d);
        txq.push_back(d);
    endtask

    // monitor side: link takes a byte, compare with scoreboard
    task automatic lnk_take(input string tag);
        logic [7:0] e;
        @(negedge clk);
        e = (txq.size() != 0) ? txq.pop_front() : 8'h00;
        check(tag, {24'd0, lnk_tx_data}, {24'd0, e});
        lnk_tx_pop = 1;
        @(posedge clk); #1 lnk_tx_pop = 0;
    endtask

    task automatic lnk_give(input logic [7:0] d);
        @(negedge clk); lnk_rx_push = 1; lnk_rx_data = d;
        rxq.push_back(d);
        @(posedge clk); #1 lnk_rx_push = 0;
    endtask

    task automatic bus_pop(input string tag);
        logic [7:0] e;
        @(negedge clk); reg_rd = 1; reg_addr = 8'h82;
        #1 e = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
        check(tag, {24'd0, reg_rdata}, {24'd0, e});
        @(posedge clk); #1 reg_rd = 0;
    endtask

    task automatic accept();
        @(negedge clk); lnk_req_ready = 1;
        @(posedge clk); #1 lnk_req_ready = 0;
    endtask

    task automatic finish_req(input logic [2:0] c, input logic [4:0] n);
        @(negedge clk); lnk_done = 1; lnk_class = c; lnk_count = n;
        @(posedge clk); #1 lnk_done = 0;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        rd_check(8'h84, 8'h00, "R11 status");
        rd_check(8'h83, 8'h00, "R11 ctrl");
        check("R11 req_valid", {31'd0, lnk_req_valid}, 0);
        // R9 unmapped
        wr(8'h90, 8'h5A);
        rd_check(8'h90, 8'h00, "R9 unmapped");
        // R4 empty pop
        bus_pop("R4 empty read");

        // R1, R2, R3, R5, R6: write request
        wr(8'h7D, 8'h45); wr(8'h7E, 8'h23); wr(8'h7F, 8'h81);
        wr(8'h80, 8'h03);
        rd_check(8'h7F, 8'h81, "R1 readback");
        for (int i = 0; i < 4; i++) drv_tx(8'hA0 + 8'(i));
        wr(8'h83, 8'h01);
        @(negedge clk);
        check("R1 lnk_addr", {12'd0, lnk_addr}, 32'h12345);
        check("R1 lnk_cmd", {28'd0, lnk_cmd}, 8);
        check("R2 lnk_len", {27'd0, lnk_len}, 4);
        check("R5 req_valid", {31'd0, lnk_req_valid}, 1);
        rd_check(8'h83, 8'h01, "R5 busy readback");
        repeat (2) @(negedge clk);
        check("R5 req_valid held", {31'd0, lnk_req_valid}, 1);
        accept();
        for (int i = 0; i < 4; i++) lnk_take("R3 tx order");
        finish_req(3'd3, 5'd4);
        rd_check(8'h84, 8'h64, "R6 ack status");
        rd_check(8'h83, 8'h00, "R5 self clear");

        // R4 read request, 16 bytes
        wr(8'h80, 8'h0F);
        wr(8'h83, 8'h01);
        @(negedge clk);
        check("R2 len 16", {27'd0, lnk_len}, 16);
        accept();
        for (int i = 0; i < 16; i++) lnk_give(8'h30 + 8'(i));
        finish_req(3'd3, 5'd16);
        rd_check(8'h84, 8'h70, "R6 count 16");
        for (int i = 0; i < 16; i++) bus_pop("R4 rx order");
        bus_pop("R4 empty after drain");

        // R2 address-only, NACK
        wr(8'h80, 8'h85);
        rd_check(8'h80, 8'h85, "R2 readback");
        wr(8'h83, 8'h01);
        @(negedge clk);
        check("R2 no payload", {27'd0, lnk_len}, 0);
        accept();
        wr(8'h83, 8'h01); // R5 ignored while busy
        finish_req(3'd1, 5'd0);
        rd_check(8'h84, 8'h20, "R6 nack");
        rd_check(8'h83, 8'h00, "R5 busy-start ignored");

        // R6 I2C defer with count
        wr(8'h83, 8'h01); accept(); finish_req(3'd6, 5'd3);
        rd_check(8'h84, 8'hC3, "R6 i2c defer");
        // R6 invalid drops count
        wr(8'h83, 8'h01); accept(); finish_req(3'd4, 5'd5);
        rd_check(8'h84, 8'h80, "R6 invalid count");

        // R7 timeout with no acceptance
        wr(8'h83, 8'h01);
        repeat (10) @(negedge clk);
        rd_check(8'h83, 8'h01, "R7 still busy");
        repeat (15) @(negedge clk);
        rd_check(8'h83, 8'h00, "R7 cleared");
        rd_check(8'h84, 8'hE0, "R7 timeout status");

        // R8 other value no effect, 0xFF flushes
        wr(8'h76, 8'h12);
        rd_check(8'h84, 8'hE0, "R8 non-flush ignored");
        drv_tx(8'h77);
        wr(8'h83, 8'h01); accept();
        lnk_give(8'h99);
        wr(8'h76, 8'hFF);
        txq.delete(); rxq.delete();
        rd_check(8'h84, 8'h00, "R8 status cleared");
        rd_check(8'h83, 8'h00, "R8 idle");
        @(negedge clk);
        check("R8 tx emptied", {24'd0, lnk_tx_data}, 0);
        bus_pop("R8 rx emptied");

        // R10 same-cycle push and pop
        wr(8'h83, 8'h01); accept();
        lnk_give(8'h11);
        @(negedge clk);
        lnk_rx_push = 1; lnk_rx_data = 8'h22;
        reg_rd = 1; reg_addr = 8'h82;
        #1 d = reg_rdata;
        check("R10 older byte", {24'd0, d}, 32'h11);
        void'(rxq.pop_front());
        rxq.push_back(8'h22);
        @(posedge clk); #1 lnk_rx_push = 0; reg_rd = 0;
        bus_pop("R10 newer byte");
        bus_pop("R10 empty");
        finish_req(3'd3, 5'd2);
        rd_check(8'h84, 8'h62, "R6 final ack");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule